// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block turns a pixel clock into the scan timing for one digital display encoder. Two counters walk across every pixel of a line and every line of a frame. From their positions the block decodes horizontal sync, vertical sync, a data-enable strobe for the visible area, a pulse at the first pixel of each frame and a pulse at the first line of vertical blanking. Interlaced scan, pixel clock synthesis and pixel fetching are handled elsewhere.

Software sets the generator up through a 32-bit register port. The port has a write strobe, a read strobe and a byte offset that must be word aligned. Timing values are written as counts minus one. Sync edges are given as offsets past the end of the visible area, not as absolute counter positions. The visible area is the total size less the blanking length. Timing writes go into a programmed bank. That bank is copied into a working bank only at a frame boundary, or at any time while the generator is stopped, so a write made during a frame never tears the picture. The intended size is at most 1920 × 1080 visible pixels.

Top module: `rtg_top`

## Requirements
- R1: After reset, hCount and vCount are 0, de, frameStart and vblankStart are 0, hsync and vsync are 1 (both polarities reset to active low), and every writable register reads back as 0.
- R2: While enabled, hCount counts 0 … H−1 and then returns to 0, where H = (offset 0x10 bits 31:16) + 1. vCount advances by one at each line end and wraps to 0 after V−1 lines, where V = (offset 0x10 bits 15:0) + 1.
- R3: Let A = H − (offset 0x1C bits 31:16 + 1). Horizontal sync is asserted for A + s + 1 ≤ hCount < A + e + 1, where s and e are bits 31:16 and 15:0 of offset 0x14. Its active level is high when control bit 4 is 1 and low when it is 0.
- R4: Vertical sync applies the same rule to vCount. It uses offset 0x18 for the sync offsets, bits 15:0 of offset 0x1C for the blanking length, and control bit 3 for the polarity.
- R5: de is 1 exactly when hCount < A and vCount < B, where B = V − (offset 0x1C bits 15:0 + 1).
- R6: While control bit 1 (enable) is 0, both counters are 0, de, frameStart and vblankStart are 0, and each sync output rests at its inactive level. Clearing the enable bit returns the counters to 0 on the next cycle.
- R7: Writes to offsets 0x10, 0x14, 0x18 or 0x1C made while enabled leave the current frame unchanged. The new values apply from the next counter wrap to (0,0).
- R8: frameStart is 1 for the single cycle when an enabled generator sits at (0,0). vblankStart is 1 for the single cycle at hCount = 0, vCount = B.
- R9: A read returns data on regRdata in the cycle after regRd. Timing registers read back the full 32-bit word last written. The control register reads back only bits 1, 3 and 4. Unmapped offsets read 0.
- R10: Offset 0x3FC reads the constant ID_VALUE. Writes to it, and writes to the status register at 0x04, have no effect.
- R11: Status bit 1 (busy) reads 1 exactly when the enable bit is set. All other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Byte offset of the register, word aligned |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid the cycle after regRd |
| hCount | output | CNT_W | Pixel position within the line |
| vCount | output | CNT_W | Line position within the frame |
| hsync | output | 1 | Horizontal sync at the programmed polarity |
| vsync | output | 1 | Vertical sync at the programmed polarity |
| de | output | 1 | High inside the visible area |
| frameStart | output | 1 | One-cycle pulse at position (0,0) |
| vblankStart | output | 1 | One-cycle pulse at the first blanking line |

## Verification
A fault in a counter or in the working timing bank moves every decoded output together, so it is visible at the ports within one line. A wrong horizontal total shows up at the first line end, and a wrong vertical total within one frame. If the working bank loads at the wrong moment, a write made during a frame changes the length of the line that is in progress, and the change is visible before the next frame start. The bench runs its own model of the counters and of both register banks, and compares the counters and all five decoded outputs against that model on every cycle.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  localparam int FIELD_W = 16;
  localparam int WORD_W  = 32;

  // word indices (byte offset >> 2)
  localparam logic [7:0] IDX_CTRL  = 8'h00;
  localparam logic [7:0] IDX_STAT  = 8'h01;
  localparam logic [7:0] IDX_FMT   = 8'h04;
  localparam logic [7:0] IDX_HSYNC = 8'h05;
  localparam logic [7:0] IDX_VSYNC = 8'h06;
  localparam logic [7:0] IDX_BLANK = 8'h07;
  localparam logic [7:0] IDX_IDENT = 8'hFF;

  localparam int CTRL_EN_BIT   = 1;
  localparam int CTRL_VPOL_BIT = 3;
  localparam int CTRL_HPOL_BIT = 4;
  localparam int STAT_BUSY_BIT = 1;

  typedef struct packed {
    logic [FIELD_W-1:0] hTotM1;
    logic [FIELD_W-1:0] vTotM1;
    logic [FIELD_W-1:0] hsStartM1;
    logic [FIELD_W-1:0] hsEndM1;
    logic [FIELD_W-1:0] vsStartM1;
    logic [FIELD_W-1:0] vsEndM1;
    logic [FIELD_W-1:0] hBlankM1;
    logic [FIELD_W-1:0] vBlankM1;
  } rtgTiming_t;

  typedef struct packed {
    logic run;
    logic hsHigh;
    logic vsHigh;
  } rtgStrobe_t;

endpackage

// File: rtl/rtg_axis_decode.sv
module rtg_axis_decode
  import rtg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0]   count,
  input  logic [FIELD_W-1:0] totM1,
  input  logic [FIELD_W-1:0] blankM1,
  input  logic [FIELD_W-1:0] syncStartM1,
  input  logic [FIELD_W-1:0] syncEndM1,
  output logic               inActive,
  output logic               inSync,
  output logic               atLast,
  output logic               atActEnd
);
  localparam int SUM_W = FIELD_W + 2;

  logic [SUM_W-1:0] cntExt;
  logic [SUM_W-1:0] actLen;
  logic [SUM_W-1:0] syncOn;
  logic [SUM_W-1:0] syncOff;

  always_comb begin
    cntExt   = SUM_W'(count);
    // (tot+1) - (blank+1) visible positions
    actLen   = SUM_W'(totM1) - SUM_W'(blankM1);
    syncOn   = actLen + SUM_W'(syncStartM1) + SUM_W'(1);
    syncOff  = actLen + SUM_W'(syncEndM1) + SUM_W'(1);
    inActive = cntExt < actLen;
    inSync   = (cntExt >= syncOn) && (cntExt < syncOff);
    atLast   = cntExt == SUM_W'(totM1);
    atActEnd = cntExt == actLen;
  end

endmodule

// File: rtl/rtg_datapath.sv
module rtg_datapath
  import rtg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  rtgTiming_t       timing,
  input  rtgStrobe_t       strobe,
  output logic [CNT_W-1:0] hCount,
  output logic [CNT_W-1:0] vCount,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic             frameStart,
  output logic             vblankStart,
  output logic             frameWrap
);
  logic hInAct, hInSync, hLast, hActEnd;
  logic vInAct, vInSync, vLast, vActEnd;

  rtg_axis_decode #(.CNT_W(CNT_W)) uHoriz (
    .count(hCount), .totM1(timing.hTotM1), .blankM1(timing.hBlankM1),
    .syncStartM1(timing.hsStartM1), .syncEndM1(timing.hsEndM1),
    .inActive(hInAct), .inSync(hInSync), .atLast(hLast), .atActEnd(hActEnd)
  );

  rtg_axis_decode #(.CNT_W(CNT_W)) uVert (
    .count(vCount), .totM1(timing.vTotM1), .blankM1(timing.vBlankM1),
    .syncStartM1(timing.vsStartM1), .syncEndM1(timing.vsEndM1),
    .inActive(vInAct), .inSync(vInSync), .atLast(vLast), .atActEnd(vActEnd)
  );

  logic hZero, vZero;
  assign hZero = hCount == '0;
  assign vZero = vCount == '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCount <= '0;
      vCount <= '0;
    end else if (!strobe.run) begin
      hCount <= '0;
      vCount <= '0;
    end else if (hLast) begin
      hCount <= '0;
      vCount <= vLast ? '0 : vCount + 1'b1;
    end else begin
      hCount <= hCount + 1'b1;
    end
  end

  always_comb begin
    frameWrap   = strobe.run && hLast && vLast;
    hsync       = (strobe.run && hInSync) ? strobe.hsHigh : ~strobe.hsHigh;
    vsync       = (strobe.run && vInSync) ? strobe.vsHigh : ~strobe.vsHigh;
    de          = strobe.run && hInAct && vInAct;
    frameStart  = strobe.run && hZero && vZero;
    vblankStart = strobe.run && hZero && vActEnd;
  end

  AST_H_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run |-> (FIELD_W'(hCount) <= timing.hTotM1)) else $error("hCount past total"); // R2
  AST_H_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && $past(strobe.run) && !hZero) |-> (hCount == $past(hCount) + 1'b1)) else $error("hCount skipped"); // R2
  AST_IDLE_HOME: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |=> (hZero && vZero)) else $error("counters not homed"); // R6
  AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && timing.hTotM1 != '0 && strobe.run) |=> !frameStart) else $error("frameStart too long"); // R8

endmodule

// File: rtl/rtg_ctrl.sv
module rtg_ctrl
  import rtg_pkg::*;
#(
  parameter int          ADDR_W   = 10,
  parameter logic [31:0] ID_VALUE = 32'h5047_0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  input  logic              frameWrap,
  output rtgTiming_t        timing,
  output rtgStrobe_t        strobe
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic             wrHit;
  assign wordIdx = regAddr[ADDR_W-1:2];
  assign aligned = regAddr[1:0] == 2'b00;
  assign wrHit   = regWr && aligned;

  logic enReg, hPolReg, vPolReg;
  logic [WORD_W-1:0] fmtReg, hsReg, vsReg, blankReg;
  logic [WORD_W-1:0] fmtSh, hsSh, vsSh, blankSh;

  // programmed bank
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      hPolReg  <= 1'b0;
      vPolReg  <= 1'b0;
      fmtReg   <= '0;
      hsReg    <= '0;
      vsReg    <= '0;
      blankReg <= '0;
    end else if (wrHit) begin
      case (wordIdx)
        IDX_W'(IDX_CTRL): begin
          enReg   <= regWdata[CTRL_EN_BIT];
          vPolReg <= regWdata[CTRL_VPOL_BIT];
          hPolReg <= regWdata[CTRL_HPOL_BIT];
        end
        IDX_W'(IDX_FMT):   fmtReg   <= regWdata;
        IDX_W'(IDX_HSYNC): hsReg    <= regWdata;
        IDX_W'(IDX_VSYNC): vsReg    <= regWdata;
        IDX_W'(IDX_BLANK): blankReg <= regWdata;
        default: ;
      endcase
    end
  end

  // working bank: follows the programmed bank while stopped, else only at wrap
  logic loadShadow;
  assign loadShadow = !enReg || frameWrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fmtSh   <= '0;
      hsSh    <= '0;
      vsSh    <= '0;
      blankSh <= '0;
    end else if (loadShadow) begin
      fmtSh   <= fmtReg;
      hsSh    <= hsReg;
      vsSh    <= vsReg;
      blankSh <= blankReg;
    end
  end

  always_comb begin
    timing.hTotM1    = fmtSh[31:16];
    timing.vTotM1    = fmtSh[15:0];
    timing.hsStartM1 = hsSh[31:16];
    timing.hsEndM1   = hsSh[15:0];
    timing.vsStartM1 = vsSh[31:16];
    timing.vsEndM1   = vsSh[15:0];
    timing.hBlankM1  = blankSh[31:16];
    timing.vBlankM1  = blankSh[15:0];
    strobe.run       = enReg;
    strobe.hsHigh    = hPolReg;
    strobe.vsHigh    = vPolReg;
  end

  // read port
  logic [WORD_W-1:0] rdNext;
  always_comb begin
    rdNext = '0;
    if (aligned) begin
      case (wordIdx)
        IDX_W'(IDX_CTRL): begin
          rdNext[CTRL_EN_BIT]   = enReg;
          rdNext[CTRL_VPOL_BIT] = vPolReg;
          rdNext[CTRL_HPOL_BIT] = hPolReg;
        end
        IDX_W'(IDX_STAT):  rdNext[STAT_BUSY_BIT] = enReg;
        IDX_W'(IDX_FMT):   rdNext = fmtReg;
        IDX_W'(IDX_HSYNC): rdNext = hsReg;
        IDX_W'(IDX_VSYNC): rdNext = vsReg;
        IDX_W'(IDX_BLANK): rdNext = blankReg;
        IDX_W'(IDX_IDENT): rdNext = ID_VALUE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      regRdata <= '0;
    else if (regRd) regRdata <= rdNext;
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (enReg && !frameWrap) |=> ($stable(fmtSh) && $stable(hsSh) && $stable(vsSh) && $stable(blankSh)))
    else $error("working bank changed mid-frame"); // R7
  AST_ID_CONST: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && aligned && wordIdx == IDX_W'(IDX_IDENT)) |=> (regRdata == ID_VALUE))
    else $error("ID read wrong"); // R10
  AST_BUSY_READ: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && aligned && wordIdx == IDX_W'(IDX_STAT)) |=> (regRdata[STAT_BUSY_BIT] == strobe.run || $past(wrHit)))
    else $error("busy flag wrong"); // R11

endmodule

// File: rtl/rtg_top.sv
module rtg_top
  import rtg_pkg::*;
#(
  parameter int          ADDR_W   = 10,
  parameter int          CNT_W    = 12,
  parameter logic [31:0] ID_VALUE = 32'h5047_0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic [CNT_W-1:0]  hCount,
  output logic [CNT_W-1:0]  vCount,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              frameStart,
  output logic              vblankStart
);
  rtgTiming_t timing;
  rtgStrobe_t strobe;
  logic       frameWrap;

  rtg_ctrl #(.ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)) uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .frameWrap(frameWrap),
    .timing(timing), .strobe(strobe)
  );

  rtg_datapath #(.CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .timing(timing), .strobe(strobe),
    .hCount(hCount), .vCount(vCount), .hsync(hsync), .vsync(vsync), .de(de),
    .frameStart(frameStart), .vblankStart(vblankStart), .frameWrap(frameWrap)
  );

endmodule

// File: tb/tb_rtg_top.sv
module tb_rtg_top;
  localparam int          ADDR_W = 10;
  localparam int          CNT_W  = 12;
  localparam logic [31:0] IDV    = 32'h5047_0100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [CNT_W-1:0] hCount, vCount;
  logic hsync, vsync, de, frameStart, vblankStart;

  always #10 clk = ~clk; // 50 MHz

  rtg_top #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ID_VALUE(IDV)) dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .hCount(hCount), .vCount(vCount),
    .hsync(hsync), .vsync(vsync), .de(de), .frameStart(frameStart),
    .vblankStart(vblankStart)
  );

  int nChecks = 0;
  int nFail = 0;
  bit rasterChk = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- reference model of both banks and counters
  logic mEn = 0, mHP = 0, mVP = 0;
  logic [31:0] mFmt = 0, mHs = 0, mVs = 0, mBl = 0;
  logic [31:0] sFmt = 0, sHs = 0, sVs = 0, sBl = 0;
  int mh = 0, mv = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mEn <= 0; mHP <= 0; mVP <= 0;
      mFmt <= 0; mHs <= 0; mVs <= 0; mBl <= 0;
      sFmt <= 0; sHs <= 0; sVs <= 0; sBl <= 0;
      mh <= 0; mv <= 0;
    end else begin
      automatic int hT = int'(sFmt[31:16]);
      automatic int vT = int'(sFmt[15:0]);
      if (!mEn) begin
        mh <= 0; mv <= 0;
      end else if (mh == hT) begin
        mh <= 0;
        mv <= (mv == vT) ? 0 : mv + 1;
      end else begin
        mh <= mh + 1;
      end
      if (!mEn || (mh == hT && mv == vT)) begin
        sFmt <= mFmt; sHs <= mHs; sVs <= mVs; sBl <= mBl;
      end
      if (regWr && regAddr[1:0] == 2'b00) begin
        case (regAddr[9:2])
          8'h00: begin mEn <= regWdata[1]; mVP <= regWdata[3]; mHP <= regWdata[4]; end
          8'h04: mFmt <= regWdata;
          8'h05: mHs  <= regWdata;
          8'h06: mVs  <= regWdata;
          8'h07: mBl  <= regWdata;
          default: ;
        endcase
      end
    end
  end

  // raster monitor
  always @(negedge clk) begin
    if (rasterChk) begin
      automatic int hA = int'(sFmt[31:16]) - int'(sBl[31:16]);
      automatic int vA = int'(sFmt[15:0]) - int'(sBl[15:0]);
      automatic bit hOn = mEn && mh >= hA + int'(sHs[31:16]) + 1 && mh < hA + int'(sHs[15:0]) + 1;
      automatic bit vOn = mEn && mv >= vA + int'(sVs[31:16]) + 1 && mv < vA + int'(sVs[15:0]) + 1;
      chk("R2 hCount", 32'(hCount), 32'(mh));
      chk("R2 vCount", 32'(vCount), 32'(mv));
      chk("R3 hsync", 32'(hsync), 32'(mHP ? hOn : !hOn));
      chk("R4 vsync", 32'(vsync), 32'(mVP ? vOn : !vOn));
      chk("R5 de", 32'(de), 32'(mEn && mh < hA && mv < vA));
      chk("R8 frameStart", 32'(frameStart), 32'(mEn && mh == 0 && mv == 0));
      chk("R8 vblankStart", 32'(vblankStart), 32'(mEn && mh == 0 && mv == vA));
    end
  end

  // ---------------- read scoreboard
  logic [31:0] expQ[$];
  string tagQ[$];
  logic rdSeen = 1'b0;
  always @(posedge clk) rdSeen <= regRd;
  always @(negedge clk) begin
    if (rdSeen && expQ.size() > 0) begin
      automatic logic [31:0] e = expQ.pop_front();
      automatic string t = tagQ.pop_front();
      chk(t, regRdata, e);
    end
  end

  task automatic writeReg(input logic [9:0] a, input logic [31:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic readReg(input logic [9:0] a, input logic [31:0] e, input string tag);
    expQ.push_back(e); tagQ.push_back(tag);
    regRd = 1'b1; regAddr = a;
    @(negedge clk);
    regRd = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    int maxH;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 hCount", 32'(hCount), 0);
    chk("R1 vCount", 32'(vCount), 0);
    chk("R1 hsync idle", 32'(hsync), 1);
    chk("R1 vsync idle", 32'(vsync), 1);
    chk("R1 de", 32'(de), 0);
    chk("R1 frameStart", 32'(frameStart), 0);
    rstN = 1'b1;
    @(negedge clk);
    rasterChk = 1'b1;
    readReg(10'h000, 32'h0, "R1 ctrl reset");
    readReg(10'h010, 32'h0, "R1 fmt reset");
    readReg(10'h01C, 32'h0, "R1 blank reset");

    // program 20x12 frame, 14x8 visible
    writeReg(10'h010, {16'd19, 16'd11});
    writeReg(10'h014, {16'd1, 16'd3});
    writeReg(10'h018, {16'd0, 16'd1});
    writeReg(10'h01C, {16'd5, 16'd3});
    readReg(10'h010, {16'd19, 16'd11}, "R9 fmt readback");
    readReg(10'h014, {16'd1, 16'd3}, "R9 hsync readback");
    readReg(10'h018, {16'd0, 16'd1}, "R9 vsync readback");
    readReg(10'h01C, {16'd5, 16'd3}, "R9 blank readback");
    readReg(10'h020, 32'h0, "R9 unmapped");
    writeReg(10'h000, 32'h0000_0019);
    readReg(10'h000, 32'h0000_0018, "R9 ctrl masked");
    // R10 / R11 while stopped
    readReg(10'h3FC, IDV, "R10 id");
    writeReg(10'h3FC, 32'h0);
    readReg(10'h3FC, IDV, "R10 id after write");
    writeReg(10'h004, 32'hFFFF_FFFF);
    readReg(10'h004, 32'h0, "R11 idle status after write");
    chk("R6 hsync idle high-pol", 32'(hsync), 0);
    chk("R6 hCount idle", 32'(hCount), 0);

    // enable, active-high syncs
    writeReg(10'h000, 32'h0000_001A);
    readReg(10'h004, 32'h0000_0002, "R11 busy");
    repeat (3 * 240) @(negedge clk);

    // active-low syncs, still running
    writeReg(10'h000, 32'h0000_0002);
    repeat (240) @(negedge clk);

    // R7: mid-frame change of total size
    while (vCount != 3) @(negedge clk);
    writeReg(10'h010, {16'd23, 16'd11});
    writeReg(10'h014, {16'd2, 16'd4});
    maxH = 0;
    while (!frameStart) begin
      if (int'(hCount) > maxH) maxH = int'(hCount);
      @(negedge clk);
    end
    chk("R7 old line length kept", 32'(maxH), 19);
    @(negedge clk);
    maxH = 0;
    while (!frameStart) begin
      if (int'(hCount) > maxH) maxH = int'(hCount);
      @(negedge clk);
    end
    chk("R7 new line length applied", 32'(maxH), 23);
    repeat (300) @(negedge clk);

    // R6: stop mid-frame, polarity high
    writeReg(10'h000, 32'h0000_0018);
    repeat (5) @(negedge clk);
    chk("R6 hCount stopped", 32'(hCount), 0);
    chk("R6 vCount stopped", 32'(vCount), 0);
    chk("R6 hsync inactive", 32'(hsync), 0);
    chk("R6 vsync inactive", 32'(vsync), 0);
    chk("R6 de low", 32'(de), 0);
    readReg(10'h004, 32'h0, "R11 not busy");

    // restart with new bank picked up immediately
    writeReg(10'h01C, {16'd7, 16'd2});
    writeReg(10'h000, 32'h0000_0002);
    repeat (2 * 288) @(negedge clk);

    rasterChk = 1'b0;
    summary();
    $finish;
  end

endmodule